// File: doc/BRIEF.md
# Two-Level Multiprocessor Interrupt Controller

This block gathers a 32-bit internal interrupt bus and hands each of several processors (two by default) a 4-bit request level. Lines 1 to 15 are captured on their rising edge into one pending register that all processors share. Lines 16 to 31 are captured into a separate extended-pending register. Each processor sees these extended bits through its own extended mask, and they all reach it as the single chained request 12.

Every interrupt 1 to 15 carries a one-bit priority tier. Tier 1 beats tier 0, and inside a tier the larger interrupt number wins. Each processor has its own mask and force registers. Each processor also returns an acknowledge strobe that carries the level it has taken. That strobe clears the matching force bit, or the pending bit when the level was not forced. On an acknowledge of level 12 it also clears the chosen extended bit and records that bit's number, so the chained handler can read it.

A simple single-cycle register port gives access to every register. Reads are combinational.

Top module: `mpirq_ctrl`

## Requirements
- R1: While reset is low and after it is released, every register reads zero and every processor's request level is 0.
- R2: A 0-to-1 edge on line n (1 to 15) sets pending bit n on the next clock edge. The bit stays set after the line drops. A line that is held high does not set the bit again once it has been cleared.
- R3: Line 0 has no effect. Pending bit 0 always reads 0.
- R4: A processor's request level is the highest-numbered active interrupt in tier 1. If tier 1 has none, it is the highest-numbered active interrupt in tier 0. If there is none at all, the level is 0. The tier of interrupt n is bit n of the word at offset 0x00.
- R5: A pending interrupt n is active for processor c only when bit n of c's mask word (offset 0x40+4c, bits 15:1) is 1.
- R6: Setting bit n of processor c's force word (offset 0x80+4c) makes n active for c alone, whatever its mask. An acknowledge of level n from c then clears that force bit and leaves the pending bit unchanged.
- R7: An acknowledge of level n from any processor, where n is not forced for that processor, clears pending bit n.
- R8: When a rising edge on line n arrives in the same cycle as an acknowledge or a clear of bit n, pending bit n stays set.
- R9: Writing a 1 to bit n of the word at offset 0x0C clears pending bit n (bits 15:1) or extended bit n (bits 31:16). Writing a 0 leaves the bit unchanged.
- R10: A rising edge on line 16 to 31 sets that bit of the extended-pending field, which reads back at offset 0x04 bits 31:16. Request 12 becomes active for processor c when any extended bit ANDed with c's extended mask (mask word bits 31:16) is 1 and mask bit 12 is set.
- R11: An unforced acknowledge of level 12 from processor c clears the highest-numbered extended bit that c leaves unmasked. It also writes that bit's number (16 to 31) into c's extended-acknowledge word at offset 0xC0+4c.
- R12: The tier, mask and force words read back what was written, except that bit 0 always reads 0. Offset 0x04 reads the extended field in bits 31:16 and the pending bits in bits 15:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 32 | Internal interrupt bus; bit 0 unused |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational) |
| ack_vld | input | NCPU | Per-processor acknowledge strobe |
| ack_lvl | input | 4*NCPU | Acknowledged level, 4 bits per processor |
| irl | output | 4*NCPU | Request level, 4 bits per processor |

## Verification
The assertions assume that the interrupt lines and the acknowledge inputs change only between clock edges. They also assume that an acknowledge names a level the processor may legally take, and that the register port issues at most one write per cycle. The bench drives every input on the falling edge and raises each strobe for exactly one cycle. Each line pattern is preceded by a cycle with the lines low, so every intended edge is a clean 0-to-1 transition. Same-cycle collisions between an edge and an acknowledge are built on purpose, and only for R8.

// File: rtl/mpirq_pkg.sv
// Package mpirq_pkg
// Shared helpers for the interrupt controller: the priority search used by
// every processor port. Assumes bit 0 of every 16-bit vector is unused.
package mpirq_pkg;

    localparam int LINES      = 32;
    localparam int LO_W       = 16;
    localparam int LVL_W      = 4;
    localparam logic [3:0] CHAIN_LVL = 4'd12;

    // Return the index of the highest set bit among bits 15..1, or 0.
    function automatic logic [3:0] top_index(input logic [15:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 1; i < 16; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

    // Return the index (0..15) of the highest set bit of a 16-bit vector.
    function automatic logic [3:0] top_index_all(input logic [15:0] v);
        logic [3:0] r;
        r = 4'd0;
        for (int i = 0; i < 16; i++) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/mpirq_pending.sv
// Module mpirq_pending
// Holds the shared pending bits for lines 1..15 and the extended pending
// bits for lines 16..31. Captures 0->1 edges of the lines; a new edge
// outranks any clear request arriving in the same cycle.
// Assumes irq_lines is synchronous to clk.
module mpirq_pending
    import mpirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [LO_W-1:0]   clr_lo,
    input  logic [LO_W-1:0]   clr_hi,
    output logic [LO_W-1:0]   pend_q,
    output logic [LO_W-1:0]   ext_q
);

    logic [LINES-1:0] lines_prev;
    logic [LINES-1:0] rise;

    // Edge detect on the interrupt bus.
    assign rise = irq_lines & ~lines_prev;

    // Remember last line values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lines_prev <= '0;
        else        lines_prev <= irq_lines;
    end

    // Pending update: clear first, then new edges set (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            ext_q  <= '0;
        end else begin
            pend_q <= ((pend_q & ~clr_lo) | rise[LO_W-1:0]) & 16'hFFFE;
            ext_q  <= (ext_q & ~clr_hi) | rise[LINES-1:LO_W];
        end
    end

endmodule

// File: rtl/mpirq_cpu_port.sv
// Module mpirq_cpu_port
// One processor's view: mask (with extended mask in the upper half),
// force, two-tier priority encode, acknowledge handling and the
// extended-acknowledge record. Assumes ack_lvl is meaningful only while
// ack_vld is high; a register write to force wins over an acknowledge.
module mpirq_cpu_port
    import mpirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LO_W-1:0]   pend,
    input  logic [LO_W-1:0]   ext_pend,
    input  logic [LO_W-1:0]   tier,
    input  logic              mask_we,
    input  logic              force_we,
    input  logic [31:0]       wdata,
    input  logic              ack_vld,
    input  logic [LVL_W-1:0]  ack_lvl,
    output logic [LVL_W-1:0]  irl,
    output logic [31:0]       mask_q,
    output logic [LO_W-1:0]   force_q,
    output logic [4:0]        extack_q,
    output logic [LO_W-1:0]   pend_clr,
    output logic [LO_W-1:0]   ext_clr
);

    logic [LO_W-1:0]  ext_hit;
    logic [LO_W-1:0]  chain;
    logic [LO_W-1:0]  active;
    logic [LVL_W-1:0] hi_lvl;
    logic [LVL_W-1:0] lo_lvl;
    logic [LO_W-1:0]  ack_hot;
    logic             ack_forced;
    logic [3:0]       ext_sel;
    logic             ext_take;

    // Build this processor's active set from shared and private state.
    always_comb begin
        ext_hit = ext_pend & mask_q[31:16];
        chain   = '0;
        chain[CHAIN_LVL] = |ext_hit;
        active  = (((pend | chain) & mask_q[15:0]) | force_q) & 16'hFFFE;
    end

    // Two-tier priority encode: tier 1 first, then tier 0.
    always_comb begin
        hi_lvl = top_index(active & tier);
        lo_lvl = top_index(active & ~tier);
        irl    = (hi_lvl != 4'd0) ? hi_lvl : lo_lvl;
    end

    // Decode the acknowledge into force/pending/extended clear requests.
    always_comb begin
        ack_hot = '0;
        ack_hot[ack_lvl] = ack_vld;
        ack_hot[0]       = 1'b0;
        ack_forced = |(ack_hot & force_q);
        pend_clr   = ack_forced ? '0 : ack_hot;
        ext_sel    = top_index_all(ext_hit);
        ext_take   = ack_vld && !ack_forced && (ack_lvl == CHAIN_LVL) && (|ext_hit);
        ext_clr    = '0;
        ext_clr[ext_sel] = ext_take;
    end

    // Mask register: written only through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= wdata & 32'hFFFF_FFFE;
    end

    // Force register: write wins, otherwise an acknowledge clears its bit.
    always_ff @(posedge clk) begin
        if (!rst_n)          force_q <= '0;
        else if (force_we)   force_q <= wdata[15:0] & 16'hFFFE;
        else if (ack_forced) force_q <= force_q & ~ack_hot;
    end

    // Record the extended line number handed to the chained handler.
    always_ff @(posedge clk) begin
        if (!rst_n)        extack_q <= '0;
        else if (ext_take) extack_q <= {1'b1, ext_sel};
    end

endmodule

// File: rtl/mpirq_ctrl.sv
// Module mpirq_ctrl (top)
// Decodes the register port, holds the tier register, merges the clear
// requests of all processor ports into the shared pending logic and
// replicates one port per processor. Assumes NCPU is 1..16 and that the
// register port performs at most one access per cycle.
module mpirq_ctrl
    import mpirq_pkg::*;
#(
    parameter int NCPU = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      irq_lines,
    input  logic                  reg_en,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [31:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NCPU-1:0]       ack_vld,
    input  logic [NCPU*LVL_W-1:0] ack_lvl,
    output logic [NCPU*LVL_W-1:0] irl
);

    localparam logic [1:0] GRP_GLOBAL = 2'd0;
    localparam logic [1:0] GRP_MASK   = 2'd1;
    localparam logic [1:0] GRP_FORCE  = 2'd2;
    localparam logic [1:0] GRP_EXTACK = 2'd3;

    logic [1:0]      grp;
    logic [3:0]      idx;
    logic            wr_go;
    logic            word_ok;
    logic [LO_W-1:0] tier_q;
    logic [LO_W-1:0] pend_q;
    logic [LO_W-1:0] ext_q;
    logic [LO_W-1:0] clr_lo;
    logic [LO_W-1:0] clr_hi;

    logic [31:0]     mask_a   [NCPU];
    logic [LO_W-1:0] force_a  [NCPU];
    logic [4:0]      extack_a [NCPU];
    logic [LO_W-1:0] pclr_a   [NCPU];
    logic [LO_W-1:0] eclr_a   [NCPU];
    logic [NCPU*32-1:0]   mask_flat;
    logic [NCPU*LO_W-1:0] force_flat;

    // Address split: group in the top two bits, processor index below.
    assign grp     = reg_addr[7:6];
    assign idx     = reg_addr[5:2];
    assign word_ok = (reg_addr[1:0] == 2'b00);
    assign wr_go   = reg_en && reg_wr && word_ok;

    // Tier register at offset 0x00.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  tier_q <= '0;
        else if (wr_go && reg_addr == 8'h00)         tier_q <= reg_wdata[15:0] & 16'hFFFE;
    end

    // Merge software clears and every processor's acknowledge clears.
    always_comb begin
        clr_lo = '0;
        clr_hi = '0;
        if (wr_go && reg_addr == 8'h0C) begin
            clr_lo = reg_wdata[15:0];
            clr_hi = reg_wdata[31:16];
        end
        for (int c = 0; c < NCPU; c++) begin
            clr_lo = clr_lo | pclr_a[c];
            clr_hi = clr_hi | eclr_a[c];
        end
    end

    mpirq_pending u_pending (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .clr_lo    (clr_lo),
        .clr_hi    (clr_hi),
        .pend_q    (pend_q),
        .ext_q     (ext_q)
    );

    // One port per processor.
    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic mwe;
        logic fwe;
        assign mwe = wr_go && grp == GRP_MASK  && idx == 4'(c);
        assign fwe = wr_go && grp == GRP_FORCE && idx == 4'(c);

        mpirq_cpu_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .pend     (pend_q),
            .ext_pend (ext_q),
            .tier     (tier_q),
            .mask_we  (mwe),
            .force_we (fwe),
            .wdata    (reg_wdata),
            .ack_vld  (ack_vld[c]),
            .ack_lvl  (ack_lvl[c*LVL_W +: LVL_W]),
            .irl      (irl[c*LVL_W +: LVL_W]),
            .mask_q   (mask_a[c]),
            .force_q  (force_a[c]),
            .extack_q (extack_a[c]),
            .pend_clr (pclr_a[c]),
            .ext_clr  (eclr_a[c])
        );

        assign mask_flat[c*32 +: 32]     = mask_a[c];
        assign force_flat[c*LO_W +: LO_W] = force_a[c];
    end

    // Combinational read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (word_ok) begin
            case (grp)
                GRP_GLOBAL: begin
                    if (idx == 4'd0) reg_rdata = {16'h0, tier_q};
                    if (idx == 4'd1) reg_rdata = {ext_q, pend_q};
                end
                GRP_MASK:   if (int'(idx) < NCPU) reg_rdata = mask_a[idx];
                GRP_FORCE:  if (int'(idx) < NCPU) reg_rdata = {16'h0, force_a[idx]};
                GRP_EXTACK: if (int'(idx) < NCPU) reg_rdata = {27'h0, extack_a[idx]};
                default:    reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mpirq_checker.sv
// Module mpirq_checker
// Temporal checks on the controller, attached by bind. Keeps its own
// copy of the previous line values to know where edges happened.
module mpirq_checker #(
    parameter int NCPU = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [31:0]       irq_lines,
    input logic [15:0]       pend_q,
    input logic [15:0]       ext_q,
    input logic [NCPU*4-1:0] irl,
    input logic [NCPU-1:0]   ack_vld,
    input logic [NCPU*4-1:0] ack_lvl,
    input logic [NCPU*32-1:0] mask_flat,
    input logic [NCPU*16-1:0] force_flat,
    input logic              reg_en,
    input logic              reg_wr,
    input logic [7:0]        reg_addr
);

    logic [31:0] seen;
    logic [31:0] edge_v;

    // Checker-side edge memory.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else        seen <= irq_lines;
    end
    assign edge_v = irq_lines & ~seen;

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irl == '0 && pend_q == '0 && ext_q == '0));

    assert_edge_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_v[15:1]) |=> ((pend_q & {$past(edge_v[15:1]), 1'b0}) == {$past(edge_v[15:1]), 1'b0}));

    assert_ext_edge_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_v[31:16]) |=> ((ext_q & $past(edge_v[31:16])) == $past(edge_v[31:16])));

    for (genvar c = 0; c < NCPU; c++) begin : g_chk
        logic [3:0]  lv;
        logic [3:0]  al;
        logic [31:0] mk;
        logic [15:0] fc;
        logic        fwr;
        assign lv  = irl[c*4 +: 4];
        assign al  = ack_lvl[c*4 +: 4];
        assign mk  = mask_flat[c*32 +: 32];
        assign fc  = force_flat[c*16 +: 16];
        assign fwr = reg_en && reg_wr && (reg_addr == 8'(8'h80 + 4*c));

        assert_level_is_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (lv != 4'd0 && lv != 4'd12) |-> ((pend_q[lv] && mk[lv]) || fc[lv]));

        assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vld[c] && al != 4'd0 && al != 4'd12 && !fc[al] && !edge_v[al])
            |=> !pend_q[$past(al)]);

        assert_ack_drops_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_vld[c] && al != 4'd0 && fc[al] && !fwr) |=> !fc[$past(al)]);
    end

endmodule

bind mpirq_ctrl mpirq_checker #(.NCPU(NCPU)) u_mpirq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .pend_q     (pend_q),
    .ext_q      (ext_q),
    .irl        (irl),
    .ack_vld    (ack_vld),
    .ack_lvl    (ack_lvl),
    .mask_flat  (mask_flat),
    .force_flat (force_flat),
    .reg_en     (reg_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr)
);

// File: tb/mpirq_ctrl_bench.sv
// Bench for mpirq_ctrl: vector table walk, then directed corner cases.
module mpirq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_lines;
    logic        reg_en;
    logic        reg_wr;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [1:0]  ack_vld;
    logic [7:0]  ack_lvl;
    logic [7:0]  irl;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mpirq_ctrl #(.NCPU(2)) u_mpirq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ack_vld   (ack_vld),
        .ack_lvl   (ack_lvl),
        .irl       (irl)
    );

    // Fields: tier[71:56] lines[55:40] mask0[39:24] mask1[23:8] exp0[7:4] exp1[3:0]
    localparam logic [71:0] VEC [6] = '{
        {16'h0000, 16'h0220, 16'hFFFE, 16'hFFFE, 4'd9, 4'd9},
        {16'h0020, 16'h0220, 16'hFFFE, 16'hFFFE, 4'd5, 4'd5},
        {16'h0020, 16'h0220, 16'hFFFE, 16'h0200, 4'd5, 4'd9},
        {16'h0000, 16'h8002, 16'h0002, 16'h0000, 4'd1, 4'd0},
        {16'h000A, 16'h400A, 16'hFFFE, 16'hFFFE, 4'd3, 4'd3},
        {16'h0000, 16'h0000, 16'hFFFE, 16'hFFFE, 4'd0, 4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0; reg_en = 0; reg_wr = 0;
        reg_addr = '0; reg_wdata = '0; ack_vld = '0; ack_lvl = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_wr = 0; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_en = 0;
    endtask

    task automatic pulse(input logic [31:0] p);
        @(negedge clk);
        irq_lines = p;
        @(negedge clk);
        irq_lines = '0;
    endtask

    task automatic ack(input int c, input logic [3:0] l);
        @(negedge clk);
        ack_vld[c] = 1'b1; ack_lvl[c*4 +: 4] = l;
        @(negedge clk);
        ack_vld = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0;
        do_reset();

        // R1: quiet after reset
        @(negedge clk);
        check("R1 irl", {24'h0, irl}, 32'h0);
        rd(8'h04, d); check("R1 pending", d, 32'h0);
        rd(8'h40, d); check("R1 mask0", d, 32'h0);

        // R4 R5: table walk
        for (int v = 0; v < 6; v++) begin
            do_reset();
            wr(8'h00, {16'h0, VEC[v][71:56]});
            wr(8'h40, {16'h0, VEC[v][39:24]});
            wr(8'h44, {16'h0, VEC[v][23:8]});
            pulse({16'h0, VEC[v][55:40]});
            @(negedge clk);
            check("R4/R5 cpu0", {28'h0, irl[3:0]}, {28'h0, VEC[v][7:4]});
            check("R4/R5 cpu1", {28'h0, irl[7:4]}, {28'h0, VEC[v][3:0]});
        end

        // R12: readback
        do_reset();
        wr(8'h00, 32'h0000_AAAB); rd(8'h00, d); check("R12 tier", d, 32'h0000_AAAA);
        wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, d); check("R12 mask1", d, 32'hFFFF_FFFE);

        // R3: line 0 ignored
        do_reset();
        wr(8'h40, 32'h0000_FFFE);
        pulse(32'h1);
        @(negedge clk);
        rd(8'h04, d); check("R3 pending", d, 32'h0);
        check("R3 irl0", {28'h0, irl[3:0]}, 32'h0);

        // R2: latch holds after drop; held line does not re-set
        pulse(32'h0000_0010);
        rd(8'h04, d); check("R2 held after drop", d, 32'h0000_0010);
        @(negedge clk); irq_lines = 32'h0000_0040;
        ack(0, 4'd6);
        rd(8'h04, d); check("R2 held line no reset R7", d, 32'h0000_0010);
        irq_lines = '0;

        // R7: acknowledge clears pending
        ack(1, 4'd4);
        rd(8'h04, d); check("R7 ack clears", d, 32'h0);

        // R8: edge and ack in the same cycle
        pulse(32'h0000_0100);
        @(negedge clk);
        irq_lines = 32'h0000_0100; ack_vld[0] = 1'b1; ack_lvl[3:0] = 4'd8;
        @(negedge clk);
        ack_vld = '0; irq_lines = '0;
        rd(8'h04, d); check("R8 stays set", d, 32'h0000_0100);
        check("R8 irl0", {28'h0, irl[3:0]}, 32'd8);

        // R9: write-1-to-clear
        pulse(32'h0000_0008);
        wr(8'h0C, 32'h0000_0100);
        rd(8'h04, d); check("R9 only bit 8 cleared", d, 32'h0000_0008);
        wr(8'h0C, 32'h0000_0008);
        rd(8'h04, d); check("R9 cleared", d, 32'h0);

        // R6: force for one processor
        do_reset();
        wr(8'h40, 32'h0000_0080);
        pulse(32'h0000_0080);
        wr(8'h84, 32'h0000_0080);
        @(negedge clk);
        check("R6 cpu1 forced", {28'h0, irl[7:4]}, 32'd7);
        wr(8'h84, 32'h0000_0000);
        wr(8'h84, 32'h0000_0080);
        wr(8'h40, 32'h0);
        @(negedge clk);
        check("R6 cpu0 not forced", {28'h0, irl[3:0]}, 32'd0);
        wr(8'h40, 32'h0000_0080);
        ack(1, 4'd7);
        rd(8'h84, d); check("R6 force cleared", d, 32'h0);
        rd(8'h04, d); check("R6 pending kept", d, 32'h0000_0080);

        // R10 R11: extended lines via chained level 12
        do_reset();
        wr(8'h40, 32'h0200_1000);
        wr(8'h44, 32'h0000_1000);
        pulse(32'h0210_0000);
        @(negedge clk);
        check("R10 cpu0 chained", {28'h0, irl[3:0]}, 32'd12);
        check("R10 cpu1 ext masked", {28'h0, irl[7:4]}, 32'd0);
        rd(8'h04, d); check("R10 ext pending", d, 32'h0210_0000);
        ack(0, 4'd12);
        rd(8'hC0, d); check("R11 ext number", d, 32'd25);
        rd(8'h04, d); check("R11 ext cleared", d, 32'h0010_0000);
        check("R11 cpu0 idle", {28'h0, irl[3:0]}, 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule